// File: doc/BRIEF.md
# Floating-point minimum/maximum unit

This block returns the smaller or the larger of two floating-point operands, in single or double precision, as the minimum and maximum instructions of a scalar floating-point pipeline need. Both operands arrive as 64-bit register images. A precision select picks the format and a second select picks minimum or maximum. The result is written back as a 64-bit register image, together with an invalid-operation flag.

NaN handling follows the rule in which a NaN never wins against a number. When exactly one operand is a NaN, the other operand is returned unchanged. This holds whether the NaN is quiet or signaling. A signaling NaN still raises the invalid flag, even though the result is then an ordinary number. Only when both operands are NaN is a NaN returned, and that NaN is always the canonical one. Negative zero counts as smaller than positive zero.

In single precision, an operand counts as valid only when its upper 32 bits are all ones, which is the NaN-box. Any operand that is not correctly boxed is treated as the canonical quiet NaN. Every single-precision result is returned boxed. The unit takes one cycle: operands are captured on a clock edge when `in_valid` is high, and the result and flag appear on the registered outputs after that edge.

Top module: `fminmax_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after the edge that sampled `in_valid` high. `result` and `invalid_flag` update only on such an edge and otherwise hold their values.
- R2: When neither operand is a NaN, `want_max`=0 returns the numerically smaller operand and `want_max`=1 returns the larger one. This includes cases where the two operands have the same sign or opposite signs.
- R3: -0.0 counts as smaller than +0.0. Minimum of the two zeros returns -0.0 (sign bit set) and maximum returns +0.0, whatever the operand order.
- R4: When exactly one operand is a quiet NaN (all exponent bits one, nonzero fraction, fraction MSB one), the other operand is returned and `invalid_flag` stays 0.
- R5: When exactly one operand is a signaling NaN (all exponent bits one, nonzero fraction, fraction MSB zero), the other operand is returned unchanged and `invalid_flag` is 1. This applies to both minimum and maximum.
- R6: When both operands are NaN, the result is the canonical NaN. `invalid_flag` is 1 if either operand is signaling and 0 otherwise.
- R7: The canonical NaN is 0x7FF8000000000000 in double precision and 0xFFFFFFFF7FC00000 in single precision (boxed 0x7FC00000). No input NaN payload ever reaches the result.
- R8: With `is_single`=1, bits 63:32 of every result are all ones, and bits 31:0 carry the single-precision value.
- R9: With `is_single`=1, an operand whose bits 63:32 are not all ones acts as the canonical quiet NaN. Its low bits are never returned, and it never raises `invalid_flag`, even if its low word has a signaling pattern.
- R10: After reset, `out_valid`, `result` and `invalid_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands valid, capture on this edge |
| op_a | input | 64 | First operand register image |
| op_b | input | 64 | Second operand register image |
| is_single | input | 1 | 1 = single precision, 0 = double precision |
| want_max | input | 1 | 1 = maximum, 0 = minimum |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Selected value or canonical NaN |
| invalid_flag | output | 1 | Invalid-operation exception |

## Verification
Two functions can fall in the same cycle here. One is returning an ordinary number as the result. The other is raising the invalid flag, which normally goes with a NaN outcome. The bench provokes this by pairing a signaling NaN with a number, in both precisions and in both minimum and maximum. It requires, in the single sample after the capturing edge, both that the result equals the non-NaN operand bit for bit and that the flag is set. A mis-boxed single operand carrying a signaling pattern is also sent, to confirm that the unboxing step wins over the signaling test and leaves the flag clear.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
    localparam int WORD_W  = 64;
    localparam int HALF_W  = WORD_W / 2;
    localparam int SP_EXP  = 8;
    localparam int SP_MAN  = 23;
    localparam int DP_EXP  = 11;
    localparam int DP_MAN  = 52;
    localparam int MAG_W   = WORD_W - 1;

    localparam logic [HALF_W-1:0] SP_QNAN = 32'h7FC0_0000;
    localparam logic [WORD_W-1:0] DP_QNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [HALF_W-1:0] BOX_ONES = '1;

    // Decoded view of one operand in the selected precision.
    typedef struct packed {
        logic              sign;
        logic              is_nan;
        logic              is_snan;
        logic [MAG_W-1:0]  mag;   // magnitude, zero-extended for single
        logic [WORD_W-1:0] bits;  // value in the selected width, zero-extended
    } operand_t;
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
    import fmm_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    input  logic              is_single,
    output operand_t          opnd
);
    logic              boxed;
    logic [HALF_W-1:0] sp_word;
    logic [SP_EXP-1:0] sp_exp;
    logic [SP_MAN-1:0] sp_man;
    logic [DP_EXP-1:0] dp_exp;
    logic [DP_MAN-1:0] dp_man;
    logic              sp_nan, dp_nan;

    always_comb begin
        boxed   = (raw[WORD_W-1:HALF_W] == BOX_ONES);
        sp_word = boxed ? raw[HALF_W-1:0] : SP_QNAN;
        sp_exp  = sp_word[HALF_W-2 -: SP_EXP];
        sp_man  = sp_word[SP_MAN-1:0];
        dp_exp  = raw[WORD_W-2 -: DP_EXP];
        dp_man  = raw[DP_MAN-1:0];
        sp_nan  = (&sp_exp) && (|sp_man);
        dp_nan  = (&dp_exp) && (|dp_man);

        if (is_single) begin
            opnd.sign    = sp_word[HALF_W-1];
            opnd.is_nan  = sp_nan;
            opnd.is_snan = sp_nan && !sp_man[SP_MAN-1];
            opnd.mag     = {{(MAG_W-HALF_W+1){1'b0}}, sp_word[HALF_W-2:0]};
            opnd.bits    = {{HALF_W{1'b0}}, sp_word};
        end else begin
            opnd.sign    = raw[WORD_W-1];
            opnd.is_nan  = dp_nan;
            opnd.is_snan = dp_nan && !dp_man[DP_MAN-1];
            opnd.mag     = raw[MAG_W-1:0];
            opnd.bits    = raw;
        end
    end
endmodule

// File: rtl/fmm_order.sv
module fmm_order
    import fmm_pkg::*;
(
    input  operand_t a,
    input  operand_t b,
    input  logic     want_max,
    output logic     take_b
);
    logic a_lt_b, b_lt_a;

    always_comb begin
        if (a.sign != b.sign) begin
            // Opposite signs: negative side is smaller, so -0 < +0.
            a_lt_b = a.sign;
            b_lt_a = b.sign;
        end else if (!a.sign) begin
            a_lt_b = a.mag < b.mag;
            b_lt_a = b.mag < a.mag;
        end else begin
            a_lt_b = a.mag > b.mag;
            b_lt_a = b.mag > a.mag;
        end
        take_b = want_max ? a_lt_b : b_lt_a;
    end
endmodule

// File: rtl/fmm_select.sv
module fmm_select
    import fmm_pkg::*;
(
    input  operand_t          a,
    input  operand_t          b,
    input  logic              is_single,
    input  logic              want_max,
    output logic [WORD_W-1:0] res,
    output logic              invalid
);
    logic              take_b;
    logic [WORD_W-1:0] pick;

    fmm_order u_order (
        .a        (a),
        .b        (b),
        .want_max (want_max),
        .take_b   (take_b)
    );

    always_comb begin
        invalid = a.is_snan || b.is_snan;
        if (a.is_nan && b.is_nan)
            pick = is_single ? {{HALF_W{1'b0}}, SP_QNAN} : DP_QNAN;
        else if (a.is_nan)
            pick = b.bits;
        else if (b.is_nan)
            pick = a.bits;
        else
            pick = take_b ? b.bits : a.bits;
        res = is_single ? {BOX_ONES, pick[HALF_W-1:0]} : pick;
    end
endmodule

// File: rtl/fminmax_unit.sv
module fminmax_unit
    import fmm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              is_single,
    input  logic              want_max,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              invalid_flag
);
    logic [WORD_W-1:0] raw [2];
    operand_t          opnd [2];
    logic [WORD_W-1:0] sel_res;
    logic              sel_inv;
    logic              single_q;

    assign raw[0] = op_a;
    assign raw[1] = op_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fmm_classify u_cls (
            .raw       (raw[gi]),
            .is_single (is_single),
            .opnd      (opnd[gi])
        );
    end

    fmm_select u_sel (
        .a         (opnd[0]),
        .b         (opnd[1]),
        .is_single (is_single),
        .want_max  (want_max),
        .res       (sel_res),
        .invalid   (sel_inv)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            invalid_flag <= 1'b0;
            single_q     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result       <= sel_res;
                invalid_flag <= sel_inv;
                single_q     <= is_single;
            end
        end
    end

    // Port-level decode used only by the checks below.
    function automatic logic dbl_snan(input logic [WORD_W-1:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != '0) && !x[51];
    endfunction
    function automatic logic dbl_quiet_or_num(input logic [WORD_W-1:0] x);
        return !dbl_snan(x);
    endfunction

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(invalid_flag));

    assert_snan_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !is_single && (dbl_snan(op_a) || dbl_snan(op_b)) |=> invalid_flag);

    assert_quiet_noflag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !is_single && dbl_quiet_or_num(op_a) && dbl_quiet_or_num(op_b)
        |=> !invalid_flag);

    assert_dp_canon_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !single_q && (result[62:52] == 11'h7FF) && (result[51:0] != '0)
        |-> result == DP_QNAN);

    assert_sp_canon_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && single_q && (result[30:23] == 8'hFF) && (result[22:0] != '0)
        |-> result[31:0] == SP_QNAN);

    assert_boxed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && single_q |-> result[63:32] == BOX_ONES);
endmodule

// File: tb/tb_fminmax_unit.sv
module tb_fminmax_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        is_single = 1'b0, want_max = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        invalid_flag;

    int checks = 0;
    int fails  = 0;

    localparam logic [63:0] D_ONE   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] D_TWO   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] D_NEG3  = 64'hC008_0000_0000_0000;
    localparam logic [63:0] D_NEG1  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] D_PZ    = 64'h0;
    localparam logic [63:0] D_NZ    = 64'h8000_0000_0000_0000;
    localparam logic [63:0] D_QNAN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] D_QPAY  = 64'h7FF8_0000_0000_0123;
    localparam logic [63:0] D_SNAN  = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] D_NSNAN = 64'hFFF4_0000_0000_0000;
    localparam logic [63:0] S_ONE   = 64'hFFFF_FFFF_3F80_0000;
    localparam logic [63:0] S_NEG2  = 64'hFFFF_FFFF_C000_0000;
    localparam logic [63:0] S_SNAN  = 64'hFFFF_FFFF_7F80_0001;
    localparam logic [63:0] S_QPAY  = 64'hFFFF_FFFF_7FC0_0055;
    localparam logic [63:0] S_CANON = 64'hFFFF_FFFF_7FC0_0000;

    fminmax_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .is_single(is_single), .want_max(want_max),
        .out_valid(out_valid), .result(result), .invalid_flag(invalid_flag)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act_r, input logic act_f,
                         input logic act_v, input logic [63:0] exp_r, input logic exp_f,
                         input logic exp_v);
        checks++;
        if (act_r !== exp_r || act_f !== exp_f || act_v !== exp_v) begin
            fails++;
            $display("FAIL %s: result=%h flag=%b valid=%b expected result=%h flag=%b valid=%b",
                     tag, act_r, act_f, act_v, exp_r, exp_f, exp_v);
        end
    endtask

    task automatic run_op(input string tag, input logic [63:0] a, input logic [63:0] b,
                          input logic sp, input logic mx,
                          input logic [63:0] er, input logic ef);
        @(negedge clk);
        op_a = a; op_b = b; is_single = sp; want_max = mx; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, result, invalid_flag, out_valid, er, ef, 1'b1);
    endtask

    task automatic test_reset;
        check("R10 reset", result, invalid_flag, out_valid, 64'h0, 1'b0, 1'b0);
    endtask

    task automatic test_numbers;
        run_op("R2 min pos", D_ONE, D_TWO, 1'b0, 1'b0, D_ONE, 1'b0);
        run_op("R2 max pos", D_ONE, D_TWO, 1'b0, 1'b1, D_TWO, 1'b0);
        run_op("R2 min mixed", D_TWO, D_NEG3, 1'b0, 1'b0, D_NEG3, 1'b0);
        run_op("R2 max mixed", D_NEG3, D_TWO, 1'b0, 1'b1, D_TWO, 1'b0);
        run_op("R2 min neg", D_NEG1, D_NEG3, 1'b0, 1'b0, D_NEG3, 1'b0);
        run_op("R2 max neg", D_NEG3, D_NEG1, 1'b0, 1'b1, D_NEG1, 1'b0);
    endtask

    task automatic test_zeros;
        run_op("R3 min +0,-0", D_PZ, D_NZ, 1'b0, 1'b0, D_NZ, 1'b0);
        run_op("R3 min -0,+0", D_NZ, D_PZ, 1'b0, 1'b0, D_NZ, 1'b0);
        run_op("R3 max -0,+0", D_NZ, D_PZ, 1'b0, 1'b1, D_PZ, 1'b0);
        run_op("R3 max +0,-0", D_PZ, D_NZ, 1'b0, 1'b1, D_PZ, 1'b0);
    endtask

    task automatic test_quiet;
        run_op("R4 min qnan,num", D_QPAY, D_TWO, 1'b0, 1'b0, D_TWO, 1'b0);
        run_op("R4 max num,qnan", D_ONE, D_QNAN, 1'b0, 1'b1, D_ONE, 1'b0);
    endtask

    task automatic test_signaling;
        run_op("R5 min snan,num", D_SNAN, D_ONE, 1'b0, 1'b0, D_ONE, 1'b1);
        run_op("R5 max num,-snan", D_NEG3, D_NSNAN, 1'b0, 1'b1, D_NEG3, 1'b1);
        run_op("R5 sp max snan,num", S_SNAN, S_NEG2, 1'b1, 1'b1, S_NEG2, 1'b1);
    endtask

    task automatic test_both_nan;
        run_op("R6 R7 quiet pair", D_QNAN, D_QPAY, 1'b0, 1'b0, D_QNAN, 1'b0);
        run_op("R6 R7 snan,qnan", D_QPAY, D_SNAN, 1'b0, 1'b1, D_QNAN, 1'b1);
        run_op("R6 R7 sp pair", S_QPAY, S_SNAN, 1'b1, 1'b0, S_CANON, 1'b1);
    endtask

    task automatic test_single;
        run_op("R8 sp min", S_ONE, S_NEG2, 1'b1, 1'b0, S_NEG2, 1'b0);
        run_op("R8 sp max", S_ONE, S_NEG2, 1'b1, 1'b1, S_ONE, 1'b0);
    endtask

    task automatic test_unboxed;
        run_op("R9 unboxed a", 64'h0000_0000_3F80_0000, S_NEG2, 1'b1, 1'b1, S_NEG2, 1'b0);
        run_op("R9 unboxed snan pattern", S_ONE, 64'h0000_0000_7F80_0001, 1'b1, 1'b0,
               S_ONE, 1'b0);
        run_op("R9 both unboxed", 64'h1234_5678_3F80_0000, 64'hFFFF_FFFE_C000_0000,
               1'b1, 1'b0, S_CANON, 1'b0);
    endtask

    task automatic test_hold;
        run_op("R1 capture", D_SNAN, D_TWO, 1'b0, 1'b1, D_TWO, 1'b1);
        @(negedge clk);
        op_a = D_NEG3; op_b = D_ONE; want_max = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R1 hold while idle", result, invalid_flag, out_valid, D_TWO, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_numbers();
        test_zeros();
        test_quiet();
        test_signaling();
        test_both_nan();
        test_single();
        test_unboxed();
        test_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule